// File: doc/BRIEF.md
# Lamp End-of-Life Window Detector

This block watches a digitised lamp-ageing voltage and decides whether it has drifted outside an allowed band. The band is centred either on a fixed 2.5 V code or on a second sampled input that follows the high-voltage bus. Its half-width is either 720 mV or 220 mV. A 2-bit configuration word picks one of the four centre and half-width pairs. The comparison counts only while the ballast is in run mode. A persistence filter turns a lasting violation into a latched end-of-life fault. Any return to the band before the filter interval ends throws away the partial count.

Independently of the window, the same input drives a lamp-absence flag with hysteresis, which the surrounding control uses to detect lamp removal and re-insertion. Voltages are unsigned 12-bit codes at 2 mV per LSB, so 2.5 V is code 1250, 720 mV is 360, 220 mV is 110, 4.63 V is 2315 and 160 mV is 80.

The filter is a four-state machine. OFF is left for INSIDE when run mode is present. INSIDE moves to COUNTING on the first out-of-window sample, or straight to TRIPPED when the interval length is 0 or 1. COUNTING falls back to INSIDE when the sample returns to the band and moves to TRIPPED when the last sample of the interval is still outside. Every state except TRIPPED returns to OFF when run mode drops. TRIPPED returns to OFF only on a clear pulse.

Top module: `eol_window_det`

## Requirements
- R1: After reset, `eol_fault`, `win_viol` and `lamp_absent` are all 0.
- R2: With `win_cfg` = 2'b00 (fixed centre 1250, half-width 360), `win_viol` is 1 one clock after a sample above 1610 or below 890 in run mode, and 0 for samples from 890 to 1610 inclusive.
- R3: With `win_cfg` = 2'b10 (fixed centre 1250, half-width 110), the in-window range is 1140 to 1360 inclusive.
- R4: With `win_cfg` = 2'b01 (tracking, half-width 110), the window centre is `bus_code`, so the in-window range is `bus_code`-110 to `bus_code`+110. With a fixed setting, `bus_code` has no effect.
- R5: With `win_cfg` = 2'b11 (tracking, half-width 360), the in-window range is `bus_code`-360 to `bus_code`+360.
- R6: The upper bound saturates at 4095 and the lower bound saturates at 0, so no wrap-around produces a false violation.
- R7: While `run_mode` is 0, `win_viol` is 0 and no count builds up. Dropping run mode discards any partial count.
- R8: With interval length N ≥ 2, `eol_fault` rises N+1 clocks after an out-of-window sample is first applied and held. It is still 0 after N clocks.
- R9: If the sample returns inside the window before the interval completes, the count restarts from zero at the next violation.
- R10: Once set, `eol_fault` stays 1 whatever the input or run mode does, until `fault_clr` is sampled high. It is then 0 one clock later.
- R11: `lamp_absent` becomes 1 one clock after a sample above 2315, in any phase. A sample of exactly 2315 does not set it.
- R12: `lamp_absent` clears one clock after a sample below 2235. Samples from 2235 to 2315 hold its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_mode | input | 1 | High while the ballast is in run mode |
| win_cfg | input | 2 | Centre and half-width selection |
| lamp_code | input | 12 | Sampled lamp-ageing voltage |
| bus_code | input | 12 | Sampled bus-proportional voltage (tracking centre) |
| filt_len | input | 16 | Persistence interval in clock cycles |
| fault_clr | input | 1 | Clears a latched fault |
| win_viol | output | 1 | Registered out-of-window indication |
| eol_fault | output | 1 | Latched end-of-life fault |
| lamp_absent | output | 1 | Lamp-absence flag with hysteresis |

## Verification
The hardest situation to reach is a violation that ends one sample before the interval would complete and then resumes. The count must restart rather than carry on. The bench holds the sample outside for fewer samples than the interval, puts it back inside for exactly one clock, and then holds it outside again. It then checks that the fault is absent after N clocks and present after N+1. A similar sequence drops run mode for a single clock in the middle of a violation, to show that the partial count is discarded.

// File: rtl/eol_pkg.sv
package eol_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_INSIDE,
        ST_COUNTING,
        ST_TRIPPED
    } eol_state_e;

    // bit 0 selects the tracking centre
    function automatic logic cfg_tracking(input logic [1:0] cfg);
        return cfg[0];
    endfunction

    // settings 01 and 10 use the narrow half-width
    function automatic logic cfg_narrow(input logic [1:0] cfg);
        return cfg[0] ^ cfg[1];
    endfunction

endpackage

// File: rtl/eol_bounds.sv
module eol_bounds #(
    parameter int W          = 12,
    parameter int FIXED_CTR  = 1250,
    parameter int HW_WIDE    = 360,
    parameter int HW_NARROW  = 110
) (
    input  logic [1:0]   cfg,
    input  logic [W-1:0] bus_code,
    output logic [W-1:0] lo_bound,
    output logic [W-1:0] hi_bound
);
    import eol_pkg::*;

    localparam logic [W-1:0] CTR_C    = W'(FIXED_CTR);
    localparam logic [W-1:0] WIDE_C   = W'(HW_WIDE);
    localparam logic [W-1:0] NARROW_C = W'(HW_NARROW);

    logic [W-1:0] centre;
    logic [W-1:0] half;
    logic [W:0]   upper_sum;

    always_comb begin
        centre    = cfg_tracking(cfg) ? bus_code : CTR_C;
        half      = cfg_narrow(cfg) ? NARROW_C : WIDE_C;
        upper_sum = {1'b0, centre} + {1'b0, half};
        hi_bound  = upper_sum[W] ? {W{1'b1}} : upper_sum[W-1:0];
        lo_bound  = (centre < half) ? '0 : (centre - half);
    end

endmodule

// File: rtl/eol_absence.sv
module eol_absence #(
    parameter int W        = 12,
    parameter int ON_CODE  = 2315,
    parameter int OFF_CODE = 2235
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lamp_code,
    output logic         absent
);
    localparam logic [W-1:0] ON_C  = W'(ON_CODE);
    localparam logic [W-1:0] OFF_C = W'(OFF_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            absent <= 1'b0;
        else if (lamp_code > ON_C)
            absent <= 1'b1;
        else if (lamp_code < OFF_C)
            absent <= 1'b0;
    end

endmodule

// File: rtl/eol_persist_fsm.sv
module eol_persist_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             viol,
    input  logic [CNT_W-1:0] len,
    input  logic             clr,
    output logic             fault
);
    import eol_pkg::*;

    eol_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W:0]   cnt_plus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        cnt_plus  = {1'b0, cnt} + 1'b1;
        unique case (state)
            ST_OFF: begin
                cnt_nxt = '0;
                if (run)
                    state_nxt = ST_INSIDE;
            end
            ST_INSIDE: begin
                cnt_nxt = '0;
                if (!run) begin
                    state_nxt = ST_OFF;
                end else if (viol) begin
                    if (len <= CNT_W'(1)) begin
                        state_nxt = ST_TRIPPED;
                    end else begin
                        state_nxt = ST_COUNTING;
                        cnt_nxt   = CNT_W'(1);
                    end
                end
            end
            ST_COUNTING: begin
                if (!run) begin
                    state_nxt = ST_OFF;
                    cnt_nxt   = '0;
                end else if (!viol) begin
                    state_nxt = ST_INSIDE;
                    cnt_nxt   = '0;
                end else if (cnt_plus >= {1'b0, len}) begin
                    state_nxt = ST_TRIPPED;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_plus[CNT_W-1:0];
                end
            end
            ST_TRIPPED: begin
                cnt_nxt = '0;
                if (clr)
                    state_nxt = ST_OFF;
            end
            default: begin
                state_nxt = ST_OFF;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_comb begin
        fault = (state == ST_TRIPPED);
    end

endmodule

// File: rtl/eol_window_det.sv
module eol_window_det #(
    parameter int W            = 12,
    parameter int MV_PER_LSB   = 2,
    parameter int CENTRE_MV    = 2500,
    parameter int HW_WIDE_MV   = 720,
    parameter int HW_NARROW_MV = 220,
    parameter int ABSENT_MV    = 4630,
    parameter int ABS_HYST_MV  = 160,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_mode,
    input  logic [1:0]       win_cfg,
    input  logic [W-1:0]     lamp_code,
    input  logic [W-1:0]     bus_code,
    input  logic [CNT_W-1:0] filt_len,
    input  logic             fault_clr,
    output logic             win_viol,
    output logic             eol_fault,
    output logic             lamp_absent
);
    localparam int CTR_CODE   = CENTRE_MV / MV_PER_LSB;
    localparam int WIDE_CODE  = HW_WIDE_MV / MV_PER_LSB;
    localparam int NARR_CODE  = HW_NARROW_MV / MV_PER_LSB;
    localparam int ABS_ON     = ABSENT_MV / MV_PER_LSB;
    localparam int ABS_OFF    = (ABSENT_MV - ABS_HYST_MV) / MV_PER_LSB;

    logic [W-1:0] lo_b, hi_b;
    logic         outside;

    eol_bounds #(
        .W(W), .FIXED_CTR(CTR_CODE), .HW_WIDE(WIDE_CODE), .HW_NARROW(NARR_CODE)
    ) u_bounds (
        .cfg(win_cfg), .bus_code(bus_code), .lo_bound(lo_b), .hi_bound(hi_b)
    );

    always_comb begin
        outside = run_mode && ((lamp_code > hi_b) || (lamp_code < lo_b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_viol <= 1'b0;
        else
            win_viol <= outside;
    end

    eol_persist_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run_mode), .viol(win_viol),
        .len(filt_len), .clr(fault_clr), .fault(eol_fault)
    );

    eol_absence #(.W(W), .ON_CODE(ABS_ON), .OFF_CODE(ABS_OFF)) u_abs (
        .clk(clk), .rst_n(rst_n), .lamp_code(lamp_code), .absent(lamp_absent)
    );

endmodule

// File: rtl/eol_window_chk.sv
module eol_window_chk #(
    parameter int W       = 12,
    parameter int ABS_ON  = 2315,
    parameter int ABS_OFF = 2235
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_mode,
    input logic [W-1:0] lamp_code,
    input logic         fault_clr,
    input logic         win_viol,
    input logic         eol_fault,
    input logic         lamp_absent
);
    localparam logic [W-1:0] ON_C  = W'(ABS_ON);
    localparam logic [W-1:0] OFF_C = W'(ABS_OFF);

    p_viol_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |=> !win_viol);

    p_trip_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_fault) |-> $past(run_mode));

    p_trip_needs_viol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_fault) |-> $past(win_viol));

    p_fault_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_fault && !fault_clr) |=> eol_fault);

    p_fault_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_fault && fault_clr) |=> !eol_fault);

    p_absent_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_code > ON_C) |=> lamp_absent);

    p_absent_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_code < OFF_C) |=> !lamp_absent);

    p_absent_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_code >= OFF_C && lamp_code <= ON_C) |=> $stable(lamp_absent));

endmodule

bind eol_window_det eol_window_chk #(
    .W(W), .ABS_ON(ABS_ON), .ABS_OFF(ABS_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .lamp_code(lamp_code),
    .fault_clr(fault_clr), .win_viol(win_viol), .eol_fault(eol_fault),
    .lamp_absent(lamp_absent)
);

// File: tb/tb_eol_window_det.sv
module tb_eol_window_det;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_mode = 1'b0;
    logic [1:0]  win_cfg = 2'b00;
    logic [11:0] lamp_code = 12'd1250;
    logic [11:0] bus_code = 12'd1250;
    logic [15:0] filt_len = 16'd1000;
    logic        fault_clr = 1'b0;
    logic        win_viol, eol_fault, lamp_absent;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eol_window_det dut (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .win_cfg(win_cfg),
        .lamp_code(lamp_code), .bus_code(bus_code), .filt_len(filt_len),
        .fault_clr(fault_clr), .win_viol(win_viol), .eol_fault(eol_fault),
        .lamp_absent(lamp_absent)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        lamp_code = 12'd1250;
        win_cfg   = 2'b00;
        fault_clr = 1'b1;
        tick(1);
        fault_clr = 1'b0;
        tick(2);
    endtask

    task automatic viol_at(input string tag, input logic [1:0] cfg,
                           input int bus, input int lamp, input int exp);
        win_cfg   = cfg;
        bus_code  = 12'(bus);
        lamp_code = 12'(lamp);
        tick(1);
        chk(tag, int'(win_viol), exp);
    endtask

    task automatic t_reset();
        chk("R1 fault", int'(eol_fault), 0);
        chk("R1 viol", int'(win_viol), 0);
        chk("R1 absent", int'(lamp_absent), 0);
    endtask

    task automatic t_fixed_wide();
        run_mode = 1'b1; filt_len = 16'd1000;
        viol_at("R2 1610", 2'b00, 0, 1610, 0);
        viol_at("R2 1611", 2'b00, 0, 1611, 1);
        viol_at("R2 890", 2'b00, 0, 890, 0);
        viol_at("R2 889", 2'b00, 0, 889, 1);
        settle();
    endtask

    task automatic t_fixed_narrow();
        viol_at("R3 1360", 2'b10, 0, 1360, 0);
        viol_at("R3 1361", 2'b10, 0, 1361, 1);
        viol_at("R3 1140", 2'b10, 0, 1140, 0);
        viol_at("R3 1139", 2'b10, 0, 1139, 1);
        settle();
    endtask

    task automatic t_track_narrow();
        viol_at("R4 2110", 2'b01, 2000, 2110, 0);
        viol_at("R4 2111", 2'b01, 2000, 2111, 1);
        viol_at("R4 1890", 2'b01, 2000, 1890, 0);
        viol_at("R4 1889", 2'b01, 2000, 1889, 1);
        viol_at("R4 fixed ignores bus", 2'b00, 3000, 1250, 0);
        settle();
    endtask

    task automatic t_track_wide();
        viol_at("R5 1360", 2'b11, 1000, 1360, 0);
        viol_at("R5 1361", 2'b11, 1000, 1361, 1);
        viol_at("R5 640", 2'b11, 1000, 640, 0);
        viol_at("R5 639", 2'b11, 1000, 639, 1);
        settle();
    endtask

    task automatic t_saturate();
        viol_at("R6 top", 2'b11, 4000, 4095, 0);
        viol_at("R6 bottom", 2'b11, 100, 0, 0);
        settle();
    endtask

    task automatic t_run_gate();
        filt_len = 16'd5;
        run_mode = 1'b0;
        win_cfg = 2'b00; lamp_code = 12'd100;
        tick(20);
        chk("R7 viol off", int'(win_viol), 0);
        chk("R7 fault off", int'(eol_fault), 0);
        run_mode = 1'b1;
        tick(3);
        run_mode = 1'b0;
        tick(1);
        run_mode = 1'b1;
        tick(5);
        chk("R7 restart not yet", int'(eol_fault), 0);
        tick(1);
        chk("R7 restart trips", int'(eol_fault), 1);
        settle();
    endtask

    task automatic t_persist();
        filt_len = 16'd8;
        lamp_code = 12'd2000;
        tick(8);
        chk("R8 before N+1", int'(eol_fault), 0);
        tick(1);
        chk("R8 at N+1", int'(eol_fault), 1);
        settle();
    endtask

    task automatic t_restart();
        filt_len = 16'd8;
        lamp_code = 12'd2000;
        tick(6);
        lamp_code = 12'd1250;
        tick(1);
        lamp_code = 12'd2000;
        tick(8);
        chk("R9 no carry-over", int'(eol_fault), 0);
        tick(1);
        chk("R9 full interval", int'(eol_fault), 1);
    endtask

    task automatic t_latch();
        lamp_code = 12'd1250;
        run_mode  = 1'b0;
        tick(5);
        chk("R10 held", int'(eol_fault), 1);
        fault_clr = 1'b1;
        tick(1);
        fault_clr = 1'b0;
        chk("R10 cleared", int'(eol_fault), 0);
        run_mode = 1'b1;
        tick(3);
        chk("R10 stays clear", int'(eol_fault), 0);
    endtask

    task automatic t_absent();
        run_mode = 1'b0;
        lamp_code = 12'd2315; tick(1);
        chk("R11 at 2315", int'(lamp_absent), 0);
        lamp_code = 12'd2316; tick(1);
        chk("R11 at 2316", int'(lamp_absent), 1);
        lamp_code = 12'd2235; tick(1);
        chk("R12 hold at 2235", int'(lamp_absent), 1);
        lamp_code = 12'd2234; tick(1);
        chk("R12 release 2234", int'(lamp_absent), 0);
        lamp_code = 12'd2300; tick(1);
        chk("R12 hold low", int'(lamp_absent), 0);
        lamp_code = 12'd1250; tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_fixed_wide();
        t_fixed_narrow();
        t_track_narrow();
        t_track_wide();
        t_saturate();
        t_run_gate();
        t_persist();
        t_restart();
        t_latch();
        t_absent();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule